// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word clock that marks the two channels, and one data line. All three wires are asynchronous to the system clock. They are sampled through a synchronizer, and a bit is taken on each detected rising edge of the bit clock. The bit clock may stop between bits, or arrive in bursts. Bits are counted only on its edges, so gaps in it cost nothing.

A two-bit format input selects right-justified, left-justified, I2S or DSP-style framing. A two-bit length input selects a sample width of 16, 18, 20 or 24 bits. Each received sample is sign-extended to 24 bits. A completed left/right pair is presented with a one-cycle strobe in the system clock domain.

Each channel also has a silence flag. The flag rises after a long run of all-zero samples on that channel and drops on the first nonzero sample. The run length is a parameter, `ZERO_RUN`, which defaults to 1024 samples.

Top module: `pcm_serial_rx`

## Requirements
- R1: With `fmt_sel` = 01 (left-justified), a word clock high marks the left channel. The MSB is the bit taken at the first bit-clock edge after the word clock changes level.
- R2: With `fmt_sel` = 10 (I2S), a word clock low marks the left channel. The MSB is taken one bit-clock edge after the word clock changes level.
- R3: With `fmt_sel` = 00 (right-justified), a word clock high marks the left channel. The sample is the last N bits taken before the word clock changes level.
- R4: With `fmt_sel` = 11 (DSP), a one-bit high pulse on the word clock marks the left MSB. The left sample's N bits follow, and the right sample's N bits follow at once after them.
- R5: `len_sel` selects N: 00 gives 16, 01 gives 18, 10 gives 20 and 11 gives 24. Bits beyond N in a slot are ignored, and the two's-complement sample is sign-extended to 24 bits.
- R6: `pair_valid` is a pulse of exactly one cycle. It is raised once for each right sample that follows a captured left sample, and `left_pcm`/`right_pcm` hold that pair while it is high.
- R7: Data is taken only on rising edges of the bit clock. Stopping the bit clock between bits does not change the received samples, and the outputs change only after a bit-clock edge.
- R8: A channel's zero flag rises once that channel has delivered more than `ZERO_RUN` consecutive all-zero samples. It then stays high while further zero samples arrive, because the run count saturates.
- R9: A channel's zero flag clears on the first nonzero sample of that channel. The other channel's flag is not affected.
- R10: After reset, `left_pcm`, `right_pcm`, `pair_valid` and both zero flags are all zero.
- R11: In right-justified mode, a word that carried fewer than N bit-clock edges before the word clock changed produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bclk | input | 1 | Serial bit clock, may be gated |
| ser_wclk | input | 1 | Word clock / frame marker |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing format select |
| len_sel | input | 2 | Sample width select |
| left_pcm | output | 24 | Last left sample, sign-extended |
| right_pcm | output | 24 | Last right sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe per stereo pair |
| zero_left | output | 1 | Left channel silence flag |
| zero_right | output | 1 | Right channel silence flag |

## Verification
The failure modes that matter here are internal state errors, and each shows up at the ports within the frame where it occurs. A wrong bit index or a lost start marker makes the sample shifted or truncated when `pair_valid` arrives. A wrong channel latch swaps or drops a pair at the next strobe. A zero counter that fails to clear or to saturate shows as a wrong flag level at the very next pair. Frames are sent in every format and at several widths, with gated bit clocks, with a short right-justified word, and with a zero run that crosses the threshold.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int IDX_W    = 6;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // sample width selected by the two-bit length code
  function automatic logic [IDX_W-1:0] word_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return IDX_W'(16);
      2'b01:   return IDX_W'(18);
      2'b10:   return IDX_W'(20);
      default: return IDX_W'(24);
    endcase
  endfunction

  // keep the low n bits of v and sign-extend them to the full width
  function automatic logic [SAMPLE_W-1:0] take_word(input logic [SAMPLE_W-1:0] v,
                                                    input logic [IDX_W-1:0] n);
    logic [IDX_W-1:0]    sh;
    logic [SAMPLE_W-1:0] t;
    sh = IDX_W'(SAMPLE_W) - n;
    t  = v << sh;
    return $unsigned($signed(t) >>> sh);
  endfunction
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= async_in;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sync_out  = pipe[STAGES-1];
  assign sync_prev = pipe[STAGES];
endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_evt,
  input  logic                w_bit,
  input  logic                d_bit,
  input  fmt_e                fmt,
  input  logic [1:0]          len_sel,
  output logic [1:0]          cap_fire,   // [0] left, [1] right
  output logic [SAMPLE_W-1:0] cap_word,
  output logic [SAMPLE_W-1:0] left_pcm,
  output logic [SAMPLE_W-1:0] right_pcm,
  output logic                pair_valid
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [SAMPLE_W-1:0] sr, next_sr;
  logic                prev_w, chg_d, armed, chan_left, have_left;
  logic [IDX_W-1:0]    bcnt, idx, n, n_last, n2_last;
  logic                w_edge, start, start_left, armed_n, cur_left;

  assign n       = word_len(len_sel);
  assign n_last  = n - IDX_W'(1);
  assign n2_last = (n << 1) - IDX_W'(1);
  assign w_edge  = w_bit ^ prev_w;
  assign next_sr = {sr[SAMPLE_W-2:0], d_bit};

  always_comb begin
    case (fmt)
      FMT_I2S: begin start = chg_d;          start_left = ~w_bit; end
      FMT_DSP: begin start = w_bit & ~prev_w; start_left = 1'b1;   end
      default: begin start = w_edge;         start_left = w_bit;  end
    endcase
  end

  assign idx      = start ? '0 : ((bcnt == IDX_MAX) ? IDX_MAX : bcnt + IDX_W'(1));
  assign armed_n  = armed | start;
  assign cur_left = start ? start_left : chan_left;

  always_comb begin
    cap_fire = 2'b00;
    cap_word = take_word(next_sr, n);
    if (bit_evt) begin
      case (fmt)
        FMT_RJ: begin
          cap_word = take_word(sr, n);
          if (w_edge && bcnt >= n_last) cap_fire = prev_w ? 2'b01 : 2'b10;
        end
        FMT_DSP: begin
          if (armed_n && idx == n_last)  cap_fire = 2'b01;
          if (armed_n && idx == n2_last) cap_fire = 2'b10;
        end
        default: begin
          if (armed_n && idx == n_last) cap_fire = cur_left ? 2'b01 : 2'b10;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; prev_w <= 1'b0; chg_d <= 1'b0; armed <= 1'b0;
      chan_left <= 1'b0; bcnt <= '0;
    end else if (bit_evt) begin
      sr        <= next_sr;
      prev_w    <= w_bit;
      chg_d     <= w_edge;
      armed     <= armed_n;
      chan_left <= cur_left;
      bcnt      <= idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_pcm <= '0; right_pcm <= '0; pair_valid <= 1'b0; have_left <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (cap_fire[0]) begin
        left_pcm  <= cap_word;
        have_left <= 1'b1;
      end
      if (cap_fire[1]) begin
        right_pcm  <= cap_word;
        pair_valid <= have_left;
        have_left  <= 1'b0;
      end
    end
  end

  // sign bits above the selected width
  logic [SAMPLE_W-1:0] upper_bits;
  assign upper_bits = $unsigned($signed(cap_word) >>> n_last);

  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire != 2'b00) |-> (upper_bits == '0 || upper_bits == '1));

  assert_pair_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  assert_pair_after_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(cap_fire[1]));

  assert_hold_between_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_evt) |-> ($stable(left_pcm) && $stable(right_pcm)));
endmodule

// File: rtl/pcm_rx_zero_det.sv
module pcm_rx_zero_det
  import pcm_rx_pkg::*;
#(
  parameter int ZERO_RUN = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_fire,
  input  logic [SAMPLE_W-1:0] smp_word,
  output logic                zero_flag
);
  localparam int CW = $clog2(ZERO_RUN + 2);
  localparam logic [CW-1:0] LIMIT = CW'(ZERO_RUN + 1);

  logic [CW-1:0] zcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     zcnt <= '0;
    else if (smp_fire) begin
      if (smp_word != '0)           zcnt <= '0;
      else if (zcnt != LIMIT)       zcnt <= zcnt + CW'(1);
    end
  end

  assign zero_flag = (zcnt == LIMIT);

  assert_clear_on_signal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_fire && smp_word != '0) |=> !zero_flag);

  assert_rise_needs_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(smp_fire && smp_word == '0));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int ZERO_RUN    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_bclk,
  input  logic        ser_wclk,
  input  logic        ser_data,
  input  logic [1:0]  fmt_sel,
  input  logic [1:0]  len_sel,
  output logic [23:0] left_pcm,
  output logic [23:0] right_pcm,
  output logic        pair_valid,
  output logic        zero_left,
  output logic        zero_right
);
  logic [2:0]          s_now, s_prev;
  logic                bit_evt;
  logic [1:0]          cap_fire;
  logic [SAMPLE_W-1:0] cap_word;
  logic [1:0]          zflag;

  pcm_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_data, ser_wclk, ser_bclk}),
    .sync_out(s_now), .sync_prev(s_prev)
  );

  assign bit_evt = s_now[0] & ~s_prev[0];

  pcm_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt),
    .w_bit(s_now[1]), .d_bit(s_now[2]),
    .fmt(fmt_e'(fmt_sel)), .len_sel(len_sel),
    .cap_fire(cap_fire), .cap_word(cap_word),
    .left_pcm(left_pcm), .right_pcm(right_pcm), .pair_valid(pair_valid)
  );

  for (genvar c = 0; c < 2; c++) begin : g_zero
    pcm_rx_zero_det #(.ZERO_RUN(ZERO_RUN)) u_zero (
      .clk(clk), .rst_n(rst_n),
      .smp_fire(cap_fire[c]), .smp_word(cap_word),
      .zero_flag(zflag[c])
    );
  end

  assign zero_left  = zflag[0];
  assign zero_right = zflag[1];

  assert_pair_on_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(bit_evt));
endmodule

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;
  localparam int ZR = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ser_bclk, ser_wclk, ser_data;
  logic [1:0] fmt_sel, len_sel;
  logic [23:0] left_pcm, right_pcm;
  logic pair_valid, zero_left, zero_right;

  pcm_serial_rx #(.ZERO_RUN(ZR)) i_pcm_serial_rx (
    .clk(clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_wclk(ser_wclk),
    .ser_data(ser_data), .fmt_sel(fmt_sel), .len_sel(len_sel),
    .left_pcm(left_pcm), .right_pcm(right_pcm), .pair_valid(pair_valid),
    .zero_left(zero_left), .zero_right(zero_right)
  );

  int checks = 0, errors = 0;
  int bit_no = 0, gap_every = 0;
  int zl_cnt = 0, zr_cnt = 0;
  logic [23:0] exp_l[$], exp_r[$];
  logic exp_zl[$], exp_zr[$];
  string exp_tag[$];
  bit done = 0;

  task automatic check24(string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  function automatic logic [23:0] ext(logic [23:0] v, int n);
    int val;
    val = int'(v) & ((1 << n) - 1);
    if (val >= (1 << (n - 1))) val = val - (1 << n);
    return 24'(val);
  endfunction

  function automatic int width_of(logic [1:0] sel);
    return (sel == 2'b00) ? 16 : (sel == 2'b01) ? 18 : (sel == 2'b10) ? 20 : 24;
  endfunction

  task automatic drive_bit(logic w, logic d);
    @(negedge clk); ser_wclk = w; ser_data = d; ser_bclk = 1'b0;
    @(negedge clk);
    @(negedge clk); ser_bclk = 1'b1;
    @(negedge clk);
    bit_no++;
    if (gap_every != 0 && bit_no % gap_every == 0) repeat (9) @(negedge clk);
  endtask

  function automatic logic rest_level(logic [1:0] f);
    return (f == 2'b10);
  endfunction

  task automatic do_reset(logic [1:0] f, logic [1:0] l);
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = f; len_sel = l;
    ser_bclk = 1'b0; ser_data = 1'b0; ser_wclk = rest_level(f);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    zl_cnt = 0; zr_cnt = 0; bit_no = 0;
    drive_bit(rest_level(f), 1'b0);
    drive_bit(rest_level(f), 1'b0);
  endtask

  task automatic finish_seq();
    repeat (3) drive_bit((fmt_sel == 2'b00) ? 1'b1 : rest_level(fmt_sel), 1'b0);
    repeat (20) @(negedge clk);
  endtask

  task automatic push_expect(logic [23:0] l, logic [23:0] r, string tag);
    int n;
    logic [23:0] el, er;
    n = width_of(len_sel);
    el = ext(l, n); er = ext(r, n);
    zl_cnt = (el == 0) ? ((zl_cnt < ZR + 1) ? zl_cnt + 1 : zl_cnt) : 0;
    zr_cnt = (er == 0) ? ((zr_cnt < ZR + 1) ? zr_cnt + 1 : zr_cnt) : 0;
    exp_l.push_back(el); exp_r.push_back(er);
    exp_zl.push_back(zl_cnt > ZR); exp_zr.push_back(zr_cnt > ZR);
    exp_tag.push_back(tag);
  endtask

  task automatic send_frame(logic [23:0] l, logic [23:0] r, string tag);
    int n;
    n = width_of(len_sel);
    push_expect(l, r, tag);
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < 32; i++) begin
        logic w, d;
        logic [23:0] s;
        int k;
        s = (h == 0) ? l : r;
        d = 1'b0;
        k = h * 32 + i;
        case (fmt_sel)
          2'b01: begin w = (h == 0); if (i < n) d = s[n-1-i]; end
          2'b10: begin w = (h == 1); if (i >= 1 && i <= n) d = s[n-i]; end
          2'b00: begin w = (h == 0); if (i >= 32 - n) d = s[31-i]; end
          default: begin
            w = (k == 0);
            if (k < n) d = l[n-1-k];
            else if (k < 2 * n) d = r[2*n-1-k];
          end
        endcase
        drive_bit(w, d);
      end
    end
  endtask

  // monitor / scoreboard
  initial begin : monitor
    bit pend;
    pend = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        check1("R6 strobe width", pair_valid, 1'b0);
        pend = 0;
      end else if (pair_valid) begin
        pend = 1;
        if (exp_l.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected pair: actual L=%h R=%h expected none", left_pcm, right_pcm);
        end else begin
          string t;
          t = exp_tag.pop_front();
          check24({t, " left"},  left_pcm,  exp_l.pop_front());
          check24({t, " right"}, right_pcm, exp_r.pop_front());
          check1({t, " zero_left"},  zero_left,  exp_zl.pop_front());
          check1({t, " zero_right"}, zero_right, exp_zr.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; ser_bclk = 1'b0; ser_wclk = 1'b0; ser_data = 1'b0;
    fmt_sel = 2'b01; len_sel = 2'b11;
    repeat (5) @(negedge clk);
    // R10: reset state
    check24("R10 left_pcm reset", left_pcm, 24'h0);
    check24("R10 right_pcm reset", right_pcm, 24'h0);
    check1("R10 pair_valid reset", pair_valid, 1'b0);
    check1("R10 zero_left reset", zero_left, 1'b0);
    check1("R10 zero_right reset", zero_right, 1'b0);

    // R1: left-justified, 24 bits
    do_reset(2'b01, 2'b11);
    send_frame(24'h123456, 24'hFEDCBA, "R1 lj24 a");
    send_frame(24'h800000, 24'h7FFFFF, "R1 lj24 b");
    finish_seq();

    // R2: I2S, 16 bits
    do_reset(2'b10, 2'b00);
    send_frame(24'h001234, 24'h00ABCD, "R2 i2s16 a");
    send_frame(24'h008000, 24'h000001, "R2 i2s16 b");
    finish_seq();

    // R3: right-justified, 20 bits
    do_reset(2'b00, 2'b10);
    send_frame(24'h054321, 24'h0F0F0F, "R3 rj20 a");
    send_frame(24'h080001, 24'h07FFFE, "R3 rj20 b");
    finish_seq();

    // R4: DSP, 18 bits
    do_reset(2'b11, 2'b01);
    send_frame(24'h02AAAA, 24'h015555, "R4 dsp18 a");
    send_frame(24'h020000, 24'h01FFFF, "R4 dsp18 b");
    finish_seq();

    // R5: bits above N ignored, sign extension
    do_reset(2'b01, 2'b00);
    send_frame(24'h5AC001, 24'hFF7FFF, "R5 lj16 ext");
    do_reset(2'b01, 2'b01);
    send_frame(24'hF20000, 24'h01FFFF, "R5 lj18 ext");
    finish_seq();

    // R7: gated bit clock
    gap_every = 3;
    do_reset(2'b01, 2'b10);
    send_frame(24'h0ABCDE, 24'h08F00F, "R7 gated lj20");
    do_reset(2'b10, 2'b11);
    send_frame(24'hC0FFEE, 24'h31337A, "R7 gated i2s24");
    finish_seq();
    gap_every = 0;

    // R11: short right-justified word gives no sample
    do_reset(2'b00, 2'b00);
    for (int i = 0; i < 8; i++) drive_bit(1'b1, 1'b1);
    for (int i = 0; i < 32; i++) drive_bit(1'b0, (i >= 16) ? i[0] : 1'b0);
    check24("R11 short word not captured", left_pcm, 24'h0);
    send_frame(24'h004321, 24'h00BEEF, "R11 after short word");
    finish_seq();

    // R8/R9: zero runs
    do_reset(2'b01, 2'b00);
    for (int i = 0; i < 9; i++) send_frame(24'h0, 24'h0, "R8 zero run");
    send_frame(24'h000005, 24'h0, "R9 left clears");
    send_frame(24'h0, 24'h00FFFF, "R9 right clears");
    finish_seq();

    repeat (50) @(negedge clk);
    checks++;
    if (exp_l.size() != 0) begin
      errors++;
      $display("FAIL R6 pairs missing: actual=%0d pending expected=0", exp_l.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule